// File: doc/BRIEF.md
# Radio Transceiver SPI Register Access Master

This block is the SPI master that a host uses to reach the register file of an external radio transceiver. The host presents one request: a 16-bit register address, a read/write flag, a burst flag, a byte count and up to sixteen bytes of write data. The block frames a transaction header, clocks the data bytes in SPI mode 0, gathers any read bytes into a local 16-byte buffer and pulses `done` when chip select has been released. The header length depends on the address. When the upper address byte is zero, a one-byte header carries the two command bits and six address bits. When the upper byte is nonzero, a two-byte header carries fourteen address bits.

A second kind of request, the command strobe, sends one bare byte with no command or address field. The byte clocked back from the radio during a strobe is reduced to its upper nibble and kept as the chip status. The block also splits that status into a ready flag and a three-bit chip state code for the host.

The serial clock runs at a fixed fraction of the system clock, set by a parameter. The block accepts a new request only while it is idle.

Top module: `radio_spi_master`

## Requirements
- R1: After reset `cs_n` is high, `sclk` is low, and `busy` and `done` are low.
- R2: Every non-strobe transaction opens with the read flag (1 = read) and then the burst flag, as the first two bits on `mosi`.
- R3: When `req_addr[15:8]` is zero, the header is 8 bits long: the two command bits, then `req_addr[5:0]` MSB first. `req_addr[7:6]` is not sent.
- R4: When `req_addr[15:8]` is nonzero, the header is 16 bits long: the two command bits, then `req_addr[13:8]`, then `req_addr[7:0]`, MSB first.
- R5: A single transfer (`req_burst`=0) carries exactly 8 data bits, whatever `req_len` is. A burst carries 8×N data bits, where N is `req_len` with 0 treated as 1 and values above 16 treated as 16. The number of rising `sclk` edges equals header bits plus data bits.
- R6: On a write, data byte k is `req_wdata[8k+7:8k]` and goes out MSB first, byte 0 first. On a read, `mosi` is 0 during the data bits.
- R7: On a read, `miso` is sampled on each rising `sclk` edge after the header. Data bit j lands in buffer byte j/8 at bit 7-(j mod 8). After `done`, the byte can be read on `rd_byte` by driving its index on `rd_idx`.
- R8: A strobe (`req_strobe`=1) clocks exactly 8 bits, `req_addr[7:0]` MSB first. `status` then holds the byte received during the strobe ANDed with 0xF0.
- R9: The bus runs in SPI mode 0. `sclk` is low whenever `cs_n` is high. Each `sclk` half period lasts CLK_DIV/2 system cycles. `cs_n` falls one half period before the first rising edge and rises one half period after the last falling edge.
- R10: `busy` is high from the cycle after a request is accepted until the `done` cycle. `done` lasts one cycle, and `busy` is low during it. A `req_valid` that arrives while `busy` is high is ignored.
- R11: Write transfers and strobes leave the read buffer unchanged.
- R12: `stat_ready` is the inverse of `status[7]`, and `stat_state` is `status[6:4]`. The state codes are 0 idle, 1 receive, 2 transmit, 3 synthesizer on, 4 calibrate, 5 settling, 6 receive FIFO error, 7 transmit FIFO error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_strobe | input | 1 | 1 = command strobe, 0 = register access |
| req_read | input | 1 | 1 = register read |
| req_burst | input | 1 | 1 = multi-byte burst |
| req_addr | input | 16 | Register address, or strobe command in bits 7:0 |
| req_len | input | 5 | Burst byte count (clamped to 1..16) |
| req_wdata | input | 128 | Write bytes, byte k in bits 8k+7:8k |
| rd_idx | input | 4 | Read buffer byte index |
| rd_byte | output | 8 | Read buffer byte at `rd_idx` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Last strobe reply masked to upper nibble |
| stat_ready | output | 1 | Chip ready (inverse of status bit 7) |
| stat_state | output | 3 | Chip state code from status bits 6:4 |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to radio |
| miso | input | 1 | SPI data from radio |

## Verification
The hardest situation to reach is a second `req_valid` that arrives in the middle of a transaction. The bench raises one a few cycles into a strobe, with different fields. It then confirms that `cs_n` stays high for several half periods after `done`, which shows that the request was not queued. A second case is the buffer-preservation rule. A full-burst read fills the buffer, a write and a strobe follow, and the buffer is read back through `rd_idx` and compared with the first contents. A reference model steps the expected chip select, clock, busy and done levels cycle by cycle and collects the `mosi` bits at every modelled rising edge.

// File: rtl/radio_spi_pkg.sv
package radio_spi_pkg;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_SHIFT = 2'd1,
        XS_TRAIL = 2'd2
    } xfer_state_e;

    typedef enum logic [2:0] {
        CHIP_IDLE     = 3'd0,
        CHIP_RX       = 3'd1,
        CHIP_TX       = 3'd2,
        CHIP_SYNTH_ON = 3'd3,
        CHIP_CAL      = 3'd4,
        CHIP_SETTLE   = 3'd5,
        CHIP_RXF_ERR  = 3'd6,
        CHIP_TXF_ERR  = 3'd7
    } chip_state_e;

    localparam logic [7:0] STATUS_MASK = 8'hF0;

endpackage

// File: rtl/radio_spi_tick.sv
module radio_spi_tick #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        tick  = en && (cnt_q == LAST);
        if (en && !tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (HALF > 1) begin : g_chk
            // R9: half periods span more than one cycle
            a_r9_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/radio_spi_hdr.sv
module radio_spi_hdr (
    input  logic        strobe,
    input  logic        read,
    input  logic        burst,
    input  logic [15:0] addr,
    output logic [15:0] hdr,
    output logic        long_hdr
);
    logic [1:0] cmd;

    always_comb begin
        cmd      = {read, burst};
        long_hdr = 1'b0;
        if (strobe) begin
            hdr = {addr[7:0], 8'h00};
        end else if (addr[15:8] != 8'h00) begin
            long_hdr = 1'b1;
            hdr      = {cmd, addr[13:8], addr[7:0]};
        end else begin
            hdr = {cmd, addr[5:0], 8'h00};
        end
    end
endmodule

// File: rtl/radio_spi_rdbuf.sv
module radio_spi_rdbuf #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [2:0]       wr_bit,
    input  logic             wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_byte
            always_comb begin
                mem_d[g] = mem_q[g];
                if (we && (wr_idx == IDX_W'(g))) mem_d[g][wr_bit] = wr_val;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mem_q[g] <= 8'h00;
                else        mem_q[g] <= mem_d[g];
            end
        end
    endgenerate

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/radio_spi_master.sv
module radio_spi_master #(
    parameter int CLK_DIV   = 20,
    parameter int MAX_BYTES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_strobe,
    input  logic                     req_read,
    input  logic                     req_burst,
    input  logic [15:0]              req_addr,
    input  logic [$clog2(MAX_BYTES+1)-1:0] req_len,
    input  logic [8*MAX_BYTES-1:0]   req_wdata,
    input  logic [$clog2(MAX_BYTES)-1:0]   rd_idx,
    output logic [7:0]               rd_byte,
    output logic                     busy,
    output logic                     done,
    output logic [7:0]               status,
    output logic                     stat_ready,
    output logic [2:0]               stat_state,
    output logic                     sclk,
    output logic                     cs_n,
    output logic                     mosi,
    input  logic                     miso
);
    import radio_spi_pkg::*;

    localparam int HALF     = CLK_DIV / 2;
    localparam int IDX_W    = $clog2(MAX_BYTES);
    localparam int LEN_W    = $clog2(MAX_BYTES + 1);
    localparam int WD_W     = 8 * MAX_BYTES;
    localparam int WD_IW    = $clog2(WD_W);
    localparam int MAX_BITS = 16 + WD_W;
    localparam int BIT_W    = $clog2(MAX_BITS + 1);
    localparam logic [BIT_W-1:0] HB_SHORT = BIT_W'(8);
    localparam logic [BIT_W-1:0] HB_LONG  = BIT_W'(16);
    localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_BYTES);

    typedef struct packed {
        xfer_state_e      st;
        logic             strobe;
        logic             read;
        logic [15:0]      hdr;
        logic [BIT_W-1:0] hdr_bits;
        logic [BIT_W-1:0] nbits;
        logic [BIT_W-1:0] bitn;
        logic [WD_W-1:0]  wdata;
        logic             sclk;
        logic             cs_n;
        logic             mosi;
        logic             done;
        logic [7:0]       rxsh;
        logic [7:0]       status;
    } xfer_t;

    xfer_t d, q;

    logic [15:0]      hdr_w;
    logic             long_w;
    logic             tick;
    logic [LEN_W-1:0] eff_len;
    logic [BIT_W-1:0] hb_w;
    logic             buf_we;
    logic [IDX_W-1:0] buf_idx;
    logic [2:0]       buf_bit;
    logic [BIT_W-1:0] jc;

    radio_spi_hdr u_hdr (
        .strobe   (req_strobe),
        .read     (req_read),
        .burst    (req_burst),
        .addr     (req_addr),
        .hdr      (hdr_w),
        .long_hdr (long_w)
    );

    radio_spi_tick #(.HALF(HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.st != XS_IDLE),
        .tick  (tick)
    );

    radio_spi_rdbuf #(.DEPTH(MAX_BYTES), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (buf_we),
        .wr_idx  (buf_idx),
        .wr_bit  (buf_bit),
        .wr_val  (miso),
        .rd_idx  (rd_idx),
        .rd_data (rd_byte)
    );

    // Serial bit at position idx of the outgoing frame
    function automatic logic frame_bit(
        input logic [BIT_W-1:0] idx,
        input logic [15:0]      h,
        input logic [BIT_W-1:0] hb,
        input logic             rd,
        input logic [WD_W-1:0]  wd
    );
        logic [BIT_W-1:0] j;
        if (idx < hb) return h[4'd15 - 4'(idx)];
        j = idx - hb;
        if (rd) return 1'b0;
        return wd[WD_IW'(j ^ BIT_W'(7))];
    endfunction

    always_comb begin
        if (!req_burst || req_len == '0) eff_len = LEN_W'(1);
        else if (req_len > LEN_MAX)      eff_len = LEN_MAX;
        else                             eff_len = req_len;
        hb_w = long_w ? HB_LONG : HB_SHORT;
    end

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        buf_we  = 1'b0;
        jc      = q.bitn - q.hdr_bits;
        buf_idx = IDX_W'(jc >> 3);
        buf_bit = 3'(~jc);
        unique case (q.st)
            XS_IDLE: begin
                if (req_valid) begin
                    d.st       = XS_SHIFT;
                    d.strobe   = req_strobe;
                    d.read     = req_read && !req_strobe;
                    d.hdr      = hdr_w;
                    d.hdr_bits = hb_w;
                    d.nbits    = req_strobe ? HB_SHORT
                                            : hb_w + BIT_W'({eff_len, 3'b000});
                    d.wdata    = req_wdata;
                    d.bitn     = '0;
                    d.cs_n     = 1'b0;
                    d.sclk     = 1'b0;
                    d.mosi     = hdr_w[15];
                end
            end
            XS_SHIFT: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                        d.rxsh = {q.rxsh[6:0], miso};
                        buf_we = q.read && (q.bitn >= q.hdr_bits);
                    end else begin
                        d.sclk = 1'b0;
                        if (q.bitn == q.nbits - 1'b1) begin
                            d.st   = XS_TRAIL;
                            d.mosi = 1'b0;
                            if (q.strobe) d.status = q.rxsh & STATUS_MASK;
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                            d.mosi = frame_bit(q.bitn + 1'b1, q.hdr, q.hdr_bits,
                                               q.read, q.wdata);
                        end
                    end
                end
            end
            XS_TRAIL: begin
                if (tick) begin
                    d.st   = XS_IDLE;
                    d.cs_n = 1'b1;
                    d.done = 1'b1;
                end
            end
            default: d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= XS_IDLE;
            q.cs_n     <= 1'b1;
            q.hdr_bits <= HB_SHORT;
            q.nbits    <= HB_SHORT;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != XS_IDLE);
    assign done       = q.done;
    assign status     = q.status;
    assign stat_ready = ~q.status[7];
    assign stat_state = q.status[6:4];
    assign sclk       = q.sclk;
    assign cs_n       = q.cs_n;
    assign mosi       = q.mosi;

    a_r9_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    a_r10_cs_during_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cs_n);
    a_r5_bit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.bitn < q.nbits));
    a_r10_busy_holds_request: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(done) && $past(busy)) |-> $stable(q.nbits));
endmodule

// File: tb/radio_spi_master_tb.sv
`timescale 1ns/1ps
module radio_spi_master_tb;
    localparam int H  = 10;
    localparam int MB = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_strobe = 1'b0, req_read = 1'b0, req_burst = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [4:0]   req_len = '0;
    logic [127:0] req_wdata = '0;
    logic [3:0]   rd_idx = '0;
    logic [7:0]   rd_byte, status;
    logic         busy, done, stat_ready, sclk, cs_n, mosi;
    logic [2:0]   stat_state;
    logic         miso = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] slv [0:17];
    logic [7:0] bufm [0:15];

    always #2.5 clk = ~clk;

    radio_spi_master u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_strobe(req_strobe),
        .req_read(req_read), .req_burst(req_burst), .req_addr(req_addr),
        .req_len(req_len), .req_wdata(req_wdata), .rd_idx(rd_idx), .rd_byte(rd_byte),
        .busy(busy), .done(done), .status(status), .stat_ready(stat_ready),
        .stat_state(stat_state), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit sbit(input int i);
        return slv[i / 8][7 - (i % 8)];
    endfunction

    task automatic run_xfer(input bit stb, input bit rd, input bit bst,
                            input logic [15:0] addr, input int len,
                            input logic [127:0] wd, input bit poke, input string tag);
        bit exp_q[$];
        bit got_q[$];
        int eff, hb, n, tend, bad, first_t, rises;
        bit prev_s;
        eff = !bst ? 1 : (len < 1 ? 1 : (len > MB ? MB : len));
        if (stb) begin
            hb = 8;
            for (int b = 7; b >= 0; b--) exp_q.push_back(addr[b]);
        end else begin
            exp_q.push_back(rd);
            exp_q.push_back(bst);
            if (addr[15:8] != 0) begin
                hb = 16;
                for (int b = 13; b >= 0; b--) exp_q.push_back(addr[b]);
            end else begin
                hb = 8;
                for (int b = 5; b >= 0; b--) exp_q.push_back(addr[b]);
            end
            for (int k = 0; k < eff; k++)
                for (int b = 7; b >= 0; b--) exp_q.push_back(rd ? 1'b0 : wd[8*k+b]);
        end
        n    = exp_q.size();
        tend = (2*n + 1) * H;

        @(negedge clk);
        req_valid = 1; req_strobe = stb; req_read = rd; req_burst = bst;
        req_addr = addr; req_len = 5'(len); req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        bad = 0; first_t = -1; prev_s = 0; rises = 0;
        for (int t = 0; t <= tend; t++) begin
            bit e_cs, e_sc, e_bz, e_dn;
            e_cs = (t >= tend);
            e_sc = !e_cs && ((t / H) % 2 == 1);
            e_bz = (t < tend);
            e_dn = (t == tend);
            if (cs_n !== e_cs || sclk !== e_sc || busy !== e_bz || done !== e_dn) begin
                bad++;
                if (first_t < 0) first_t = t;
            end
            if (!prev_s && sclk === 1'b1) begin
                got_q.push_back(mosi);
                rises++;
            end
            prev_s = sclk;
            if ((t % (2*H)) == 0 && (t / (2*H)) < n) miso = sbit(t / (2*H));
            if (poke && t == 5) begin
                req_valid = 1; req_strobe = 0; req_read = 1; req_burst = 1;
                req_addr = 16'h2F01; req_len = 5'd4;
            end
            if (poke && t == 6) req_valid = 0;
            if (t < tend) @(negedge clk);
        end
        // R9 R10: cycle-by-cycle shape of cs_n, sclk, busy, done
        chk(bad == 0, {tag, " R9 R10"}, "waveform mismatches (first at cycle)",
            longint'(first_t), -1);
        // R5: number of rising sclk edges
        chk(rises == n, {tag, " R5"}, "sclk rising edges", rises, n);
        begin
            longint mism = -1;
            for (int i = 0; i < n && i < got_q.size(); i++)
                if (got_q[i] !== exp_q[i] && mism < 0) mism = i;
            chk(mism < 0, tag, "mosi bit mismatch at index", mism, -1);
        end
        if (rd && !stb) begin
            for (int k = 0; k < eff; k++) begin
                logic [7:0] eb;
                for (int b = 0; b < 8; b++) eb[7-b] = sbit(hb + 8*k + b);
                bufm[k] = eb;
            end
        end
        if (poke) begin
            int hi = 1;
            repeat (3*H) begin
                @(negedge clk);
                if (cs_n !== 1'b1 || busy !== 1'b0) hi = 0;
            end
            // R10: request raised while busy is dropped
            chk(hi == 1, "R10", "idle after ignored request", hi, 1);
        end
        @(negedge clk);
    endtask

    task automatic check_buf(input int cnt, input string tag);
        for (int k = 0; k < cnt; k++) begin
            rd_idx = 4'(k);
            #1;
            chk(rd_byte === bufm[k], tag, $sformatf("buffer byte %0d", k), rd_byte, bufm[k]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 18; i++) slv[i] = 8'(8'h3C + 8'd29 * i);
        for (int i = 0; i < 16; i++) bufm[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(cs_n === 1'b1, "R1", "cs_n", cs_n, 1);
        chk(sclk === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "sclk|busy|done",
            {sclk, busy, done}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2 R3 R6: short single write; addr bits 7:6 dropped
        run_xfer(0, 0, 0, 16'h00C5, 1, 128'hA5, 0, "R2 R3 R6 short write");
        // R4 R6: extended burst write of 3 bytes
        run_xfer(0, 0, 1, 16'h2F0C, 3, 128'h47_81_56, 0, "R4 R6 ext burst write");
        // R5: single transfer ignores len
        run_xfer(0, 0, 0, 16'h0012, 5, 128'h0000_00FF_EE_DD_CC_3B, 0, "R5 single len5");
        // R5: burst with len 0 acts as one byte
        run_xfer(0, 0, 1, 16'h001D, 0, 128'h9E, 0, "R5 burst len0");
        // R7: short single read
        run_xfer(0, 1, 0, 16'h0005, 1, '0, 0, "R2 R7 short read");
        check_buf(1, "R7 short read");
        // R5 R7: extended read, len 20 clamps to 16
        for (int i = 0; i < 18; i++) slv[i] = 8'(8'hB1 ^ (8'd17 * i));
        run_xfer(0, 1, 1, 16'h2F8F, 20, '0, 0, "R4 R5 R7 ext burst read");
        check_buf(16, "R5 R7 ext burst read");
        // R11: a burst write and a strobe leave the buffer alone
        run_xfer(0, 0, 1, 16'h0033, 16, {16{8'h5A}}, 0, "R6 R11 burst write");
        // R8 R12 R10: strobe, with a request poked in while busy
        slv[0] = 8'h2A;
        run_xfer(1, 0, 0, 16'h003D, 1, '0, 1, "R8 strobe");
        chk(status === 8'h20, "R8", "status", status, 8'h20);
        chk(stat_ready === 1'b1 && stat_state === 3'd2, "R12", "ready/state",
            {stat_ready, stat_state}, 4'hA);
        check_buf(16, "R11 after write and strobe");
        slv[0] = 8'hF5;
        run_xfer(1, 1, 1, 16'h0036, 9, '0, 0, "R8 strobe not ready");
        chk(status === 8'hF0, "R8", "status", status, 8'hF0);
        chk(stat_ready === 1'b0 && stat_state === 3'd7, "R12", "ready/state",
            {stat_ready, stat_state}, 4'h7);
        check_buf(4, "R11 after strobe");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule